// File: doc/BRIEF.md
# Fetch-Driven Pattern Bank Latch Mapper

This block turns each 13-bit pattern-space fetch address into a physical offset in character memory. Pattern space is cut into eight 1 KB pages. Each page has a base register, and the result is that base added to the full fetch address. A second table of eight base registers can stand in for the first. This happens separately for the lower and the upper 4 KB half of pattern space, under control of one latch per half.

When the latch mode is on, the fetch stream switches banks without help from the host. A fetch from tile row 0xFD of a half clears that half's latch, and a fetch from tile row 0xFE sets it. The translation of a fetch always uses the latch value from before that fetch. The mapper's register decode writes the base registers through an index, a table select and a data word. The mapped offset leaves the block one cycle after the fetch strobe, together with a valid flag.

Top module: `chrmap_bank_latch`

## Requirements
- R1: After reset `map_valid` is 0 and both half latches are clear, so a fetch made in latch mode before any latch-setting fetch uses the primary table.
- R2: With `latch_mode_en` low, the output for fetch address A is primary base[A[12:10]] + A, truncated to OFS_W bits.
- R3: `map_valid` is high in exactly the cycle after a cycle with `fetch_valid` high. `map_addr` holds its value while no fetch is presented.
- R4: With `latch_mode_en` high and the latch of the fetched half set, the output is alternate base[A[12:10]] + A.
- R5: Address bit 12 picks the latch: 0 selects the lower-half latch and 1 selects the upper-half latch. A fetch changes only the latch of its own half.
- R6: A fetch is translated with the latch value from before that fetch. A latch change takes effect from the next fetch onward.
- R7: In latch mode, a fetch with A[11:4] = 0xFD clears its half's latch and a fetch with A[11:4] = 0xFE sets it. Any other value leaves the latch unchanged.
- R8: With `latch_mode_en` low, fetches do not change either latch. Latch state from before the mode was disabled is still in effect once it is enabled again.
- R9: A write with `wr_en` high stores `wr_base` into page `wr_index` of the primary table (`wr_table` = 0) or of the alternate table (`wr_table` = 1). A fetch in the same cycle still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_mode_en | input | 1 | Enables latch-controlled table selection and latch updates |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 13 | Pattern-space fetch address |
| wr_en | input | 1 | Base register write strobe |
| wr_table | input | 1 | 0 = primary table, 1 = alternate table |
| wr_index | input | 3 | Page index of the written register |
| wr_base | input | OFS_W (18) | Base offset to store |
| map_valid | output | 1 | Registered mapped-address valid |
| map_addr | output | OFS_W (18) | Registered physical offset |

## Verification
The assertions check on every cycle that the valid flag follows the strobe by one cycle, that the output holds while idle, that each latch reacts to the 0xFD and 0xFE rows of its own half while the other half keeps its value, that the latches stay frozen with the mode off, and that a register write lands. Only the bench scenarios show the arithmetic of the translation and the choice of table. These are covered by full sweeps of all 8192 addresses with the mode off and with it on. Separate scenarios cover the old-latch ordering on the switching rows, persistence of latch state across a mode-off period, and a write issued in the same cycle as a fetch.

// File: rtl/chrmap_pkg.sv
package chrmap_pkg;
    parameter int CHR_ADDR_W = 13;
    parameter int CHR_PAGE_W = 10;
    parameter int ROW_W      = 8;
    parameter logic [ROW_W-1:0] ROW_CLEAR = 8'hFD;
    parameter logic [ROW_W-1:0] ROW_SET   = 8'hFE;
    localparam int PAGE_IDX_W = CHR_ADDR_W - CHR_PAGE_W;
    localparam int PAGE_CNT   = 1 << PAGE_IDX_W;
    localparam int TABLE_CNT  = 2;
endpackage

// File: rtl/chrmap_page_table.sv
module chrmap_page_table
    import chrmap_pkg::*;
#(
    parameter int OFS_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PAGE_IDX_W-1:0] wr_index,
    input  logic [OFS_W-1:0]      wr_data,
    input  logic [PAGE_IDX_W-1:0] rd_index,
    output logic [OFS_W-1:0]      rd_base
);
    typedef logic [OFS_W-1:0] base_t;
    typedef struct packed {
        base_t [PAGE_CNT-1:0] base;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.base[wr_index] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_base = st_q.base[rd_index];

    // R9: a write is visible in the addressed register on the next cycle
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.base[$past(wr_index)] == $past(wr_data));
endmodule

// File: rtl/chrmap_fetch_latch.sv
module chrmap_fetch_latch
    import chrmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_en,
    input  logic                  fetch_valid,
    input  logic [CHR_ADDR_W-1:0] fetch_addr,
    output logic [1:0]            latch_q
);
    typedef struct packed {
        logic [1:0] half_latch;
    } latch_state_t;

    latch_state_t st_d, st_q;
    logic             half;
    logic [ROW_W-1:0] row;

    assign half = fetch_addr[CHR_ADDR_W-1];
    assign row  = fetch_addr[CHR_ADDR_W-2 -: ROW_W];

    always_comb begin
        st_d = st_q;
        if (mode_en && fetch_valid) begin
            if (row == ROW_CLEAR) begin
                st_d.half_latch[half] = 1'b0;
            end else if (row == ROW_SET) begin
                st_d.half_latch[half] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q = st_q.half_latch;

    // R7: clearing row
    a_r7_clear_row: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && fetch_valid && row == ROW_CLEAR) |=> !latch_q[$past(half)]);
    // R7: setting row
    a_r7_set_row: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && fetch_valid && row == ROW_SET) |=> latch_q[$past(half)]);
    // R5: the other half's latch is untouched
    a_r5_other_half: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && fetch_valid) |=> latch_q[!$past(half)] == $past(latch_q[!half]));
    // R8: latches frozen while the mode is off
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> $stable(latch_q));
endmodule

// File: rtl/chrmap_bank_latch.sv
module chrmap_bank_latch
    import chrmap_pkg::*;
#(
    parameter int OFS_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  latch_mode_en,
    input  logic                  fetch_valid,
    input  logic [CHR_ADDR_W-1:0] fetch_addr,
    input  logic                  wr_en,
    input  logic                  wr_table,
    input  logic [PAGE_IDX_W-1:0] wr_index,
    input  logic [OFS_W-1:0]      wr_base,
    output logic                  map_valid,
    output logic [OFS_W-1:0]      map_addr
);
    localparam int EXT_W = OFS_W - CHR_ADDR_W;

    typedef struct packed {
        logic             valid;
        logic [OFS_W-1:0] addr;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [PAGE_IDX_W-1:0] page;
    logic [1:0]            latch_q;
    logic [OFS_W-1:0]      tbl_base [TABLE_CNT];
    logic                  use_alt;
    logic [OFS_W-1:0]      sel_base;

    assign page = fetch_addr[CHR_ADDR_W-1 -: PAGE_IDX_W];

    for (genvar t = 0; t < TABLE_CNT; t++) begin : g_table
        chrmap_page_table #(.OFS_W(OFS_W)) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_table == t[0])),
            .wr_index (wr_index),
            .wr_data  (wr_base),
            .rd_index (page),
            .rd_base  (tbl_base[t])
        );
    end

    chrmap_fetch_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_en     (latch_mode_en),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .latch_q     (latch_q)
    );

    assign use_alt  = latch_mode_en && latch_q[fetch_addr[CHR_ADDR_W-1]];
    assign sel_base = use_alt ? tbl_base[1] : tbl_base[0];

    always_comb begin
        st_d       = st_q;
        st_d.valid = fetch_valid;
        if (fetch_valid) begin
            st_d.addr = sel_base + {{EXT_W{1'b0}}, fetch_addr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_valid = st_q.valid;
    assign map_addr  = st_q.addr;

    // R3: valid follows the strobe by one cycle
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> map_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !map_valid);
    // R3: output holds while idle
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(map_addr));
endmodule

// File: tb/chrmap_bank_latch_test.sv
module chrmap_bank_latch_test;
    localparam int OFS_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              latch_mode_en = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [12:0]       fetch_addr = '0;
    logic              wr_en = 1'b0;
    logic              wr_table = 1'b0;
    logic [2:0]        wr_index = '0;
    logic [OFS_W-1:0]  wr_base = '0;
    logic              map_valid;
    logic [OFS_W-1:0]  map_addr;

    int n_chk = 0;
    int n_bad = 0;

    logic [OFS_W-1:0] m_pri [8];
    logic [OFS_W-1:0] m_alt [8];
    logic [1:0]       m_lat;
    logic [OFS_W-1:0] m_prev;

    always #2 clk = ~clk;

    chrmap_bank_latch #(.OFS_W(OFS_W)) uut (
        .clk(clk), .rst_n(rst_n), .latch_mode_en(latch_mode_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .wr_en(wr_en), .wr_table(wr_table), .wr_index(wr_index),
        .wr_base(wr_base), .map_valid(map_valid), .map_addr(map_addr)
    );

    task automatic check(input string tag, input logic [OFS_W-1:0] act,
                         input logic [OFS_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model, check after the next posedge
    task automatic step(input string tag, input logic v, input logic [12:0] a,
                        input logic mode, input logic we, input logic tbl,
                        input logic [2:0] idx, input logic [OFS_W-1:0] data);
        logic [OFS_W-1:0] exp;
        logic [2:0] pg;
        logic [7:0] row;
        @(negedge clk);
        fetch_valid = v; fetch_addr = a; latch_mode_en = mode;
        wr_en = we; wr_table = tbl; wr_index = idx; wr_base = data;
        pg  = a[12:10];
        row = a[11:4];
        exp = m_prev;
        if (v) begin
            exp = ((mode && m_lat[a[12]]) ? m_alt[pg] : m_pri[pg]) + OFS_W'(a);
            if (mode && row == 8'hFD) m_lat[a[12]] = 1'b0;
            if (mode && row == 8'hFE) m_lat[a[12]] = 1'b1;
        end
        if (we) begin
            if (tbl) m_alt[idx] = data; else m_pri[idx] = data;
        end
        @(posedge clk);
        #1;
        check({tag, " valid"}, OFS_W'(map_valid), OFS_W'(v));
        check({tag, " addr"}, map_addr, exp);
        m_prev = exp;
    endtask

    task automatic fetch(input string tag, input logic [12:0] a, input logic mode);
        step(tag, 1'b1, a, mode, 1'b0, 1'b0, 3'd0, '0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_lat = 2'b00;
        m_prev = '0;
        for (int i = 0; i < 8; i++) begin m_pri[i] = '0; m_alt[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 reset valid", OFS_W'(map_valid), '0);
        check("R1 reset addr", map_addr, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: fill both tables
        for (int i = 0; i < 8; i++) begin
            step("R9 write pri", 1'b0, '0, 1'b0, 1'b1, 1'b0, 3'(i),
                 OFS_W'((i * 37 + 5) << 10));
            step("R9 write alt", 1'b0, '0, 1'b0, 1'b1, 1'b1, 3'(i),
                 OFS_W'(((i * 91 + 200) << 10) | 3));
        end

        // R1: latches clear after reset -> primary table in latch mode
        fetch("R1 first latch-mode fetch", 13'h0123, 1'b1);
        fetch("R1 first latch-mode fetch upper", 13'h1456, 1'b1);

        // R2: full sweep with mode off (latch-setting rows included, R8)
        for (int a = 0; a < 8192; a++) fetch("R2 sweep mode off", 13'(a), 1'b0);

        // R8: latches did not move during the mode-off sweep
        fetch("R8 lower still clear", 13'h0040, 1'b1);
        fetch("R8 upper still clear", 13'h1040, 1'b1);

        // R3: idle cycles hold output and drop valid
        step("R3 idle", 1'b0, 13'h1FFF, 1'b1, 1'b0, 1'b0, 3'd0, '0);
        step("R3 idle", 1'b0, 13'h0FE0, 1'b1, 1'b0, 1'b0, 3'd0, '0);

        // R4 R5 R7: full sweep in latch mode
        for (int a = 0; a < 8192; a++) fetch("R4 R7 sweep latch mode", 13'(a), 1'b1);

        // R6: the clearing fetch itself still uses the alternate table
        fetch("R6 clear row uses old latch", 13'h0FD5, 1'b1);
        fetch("R7 lower cleared", 13'h0123, 1'b1);
        fetch("R5 upper unaffected", 13'h1123, 1'b1);
        fetch("R6 set row uses old latch", 13'h0FE7, 1'b1);
        fetch("R7 lower set", 13'h0010, 1'b1);
        fetch("R7 other row no change", 13'h0FC0, 1'b1);
        fetch("R7 other row no change", 13'h0FF0, 1'b1);
        fetch("R5 upper clear", 13'h1FD0, 1'b1);
        fetch("R5 lower kept set", 13'h0700, 1'b1);
        fetch("R5 upper cleared", 13'h1700, 1'b1);

        // R8: mode off ignores latch and freezes it; state persists
        fetch("R8 mode off primary", 13'h0700, 1'b0);
        fetch("R8 mode off clear row", 13'h0FD1, 1'b0);
        fetch("R8 state persists", 13'h0701, 1'b1);

        // R9: write in the same cycle as a fetch to the same page
        step("R9 same-cycle write old value", 1'b1, 13'h0333, 1'b0, 1'b1, 1'b0,
             3'd0, 18'h2A800);
        fetch("R9 new value visible", 13'h0333, 1'b0);
        step("R9 alt same-cycle", 1'b1, 13'h0333, 1'b1, 1'b1, 1'b1, 3'd0, 18'h15400);
        fetch("R9 alt new value", 13'h0334, 1'b1);
        fetch("R2 wraparound", 13'h1FFF, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule